// File: doc/BRIEF.md
# Signed Adder-Subtractor with Idle Blanking

This block adds or subtracts two signed two's-complement words of `WIDTH` bits (five by default: one sign bit over four magnitude bits, covering -16 to +15). Two independent command lines pick the operation. One requests a sum and the other a difference. When neither is raised, the result is forced to all zeros. Subtraction works by passing each bit of the second operand through a per-bit AND-OR selector that picks its true or its inverted value. The subtract command also feeds the carry input of the lowest adder stage, so the selected operand becomes its two's-complement negation.

The ripple of full-adder stages drops the carry out of the sign stage. A separate flag reports when the signed result cannot be held in `WIDTH` bits. The flag is the exclusive-OR of the carry entering the sign stage and the carry leaving it. It is held low while the unit is idle. The result and the flag are registered, so they appear one clock after the operands and commands are sampled. A synchronous active-high reset clears both outputs.

Top module: `signed_addsub_unit`

## Requirements
- R1: With `op_add`=1 and `op_sub`=0 sampled at a rising edge, `result` after that edge equals (`opnd_x` + `opnd_y`) modulo 2^WIDTH.
- R2: With `op_sub`=1 and `op_add`=0 sampled at a rising edge, `result` after that edge equals (`opnd_x` - `opnd_y`) modulo 2^WIDTH.
- R3: With `op_add`=0 and `op_sub`=0 sampled, `result` becomes all zeros and `ovf` becomes 0, whatever the operands are.
- R4: With `op_add`=1 and `op_sub`=1 both sampled, the unit subtracts exactly as in R2, and `ovf` follows R5 for the difference.
- R5: `ovf` is 1 exactly when the true signed sum or difference lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1. For WIDTH=5, +8 plus +12, -13 plus -7 and +12 minus -8 each set it.
- R6: The carry out of the sign stage is discarded without raising `ovf`. Examples: -1 plus -1 gives 11110 (-2) with `ovf`=0, and +5 plus -5 gives 00000 (positive zero) with `ovf`=0.
- R7: While `rst` is sampled high at a rising edge, `result` and `ovf` become 0 after that edge.
- R8: Outputs have a latency of exactly one clock. They change only at rising edges and reflect the inputs sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_add | input | 1 | Request sum |
| op_sub | input | 1 | Request difference; also takes priority when both commands are raised |
| opnd_x | input | WIDTH | Minuend / augend, two's complement |
| opnd_y | input | WIDTH | Subtrahend / addend, two's complement |
| result | output | WIDTH | Registered sum or difference, zero when idle |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
The assertions assume that `op_add`, `op_sub` and both operands are settled, known values at every rising edge. They also assume that the operands are read as two's-complement words of exactly `WIDTH` bits. The stimulus changes inputs only at falling edges and always drives them to defined values, so the one-cycle history the properties use is never taken from a half-settled cycle. The random operands cover the whole word range. The four command combinations are drawn with equal weight, so idle blanking, the both-raised case and overflow in either direction all appear often alongside the directed extremes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OPK_IDLE = 2'd0,
    OPK_ADD  = 2'd1,
    OPK_SUB  = 2'd2
  } opkind_e;

  // Difference wins when both command lines are raised.
  function automatic opkind_e decode_cmd(input logic want_add, input logic want_sub);
    if (want_sub)      return OPK_SUB;
    else if (want_add) return OPK_ADD;
    else               return OPK_IDLE;
  endfunction

endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] y_raw,
  input  logic             invert,
  output logic [WIDTH-1:0] y_eff
);
  // One AND-OR selector per bit: true value or its complement.
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign y_eff[i] = (y_raw[i] & ~invert) | (~y_raw[i] & invert);
  end
endmodule

// File: rtl/addsub_full_adder.sv
module addsub_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_to_sign,
  output logic             carry_from_sign
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    addsub_full_adder u_fa (
      .a  (a[i]),
      .b  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign carry_to_sign   = chain[MSB];
  assign carry_from_sign = chain[WIDTH];
endmodule

// File: rtl/signed_addsub_unit.sv
module signed_addsub_unit #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_add,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);
  import addsub_pkg::*;

  localparam logic [WIDTH-1:0] ZERO_W = '0;

  opkind_e         kind;
  logic            negate;
  logic            active;
  logic [WIDTH-1:0] y_sel;
  logic [WIDTH-1:0] raw_sum;
  logic            c_into_sign;
  logic            c_out_sign;
  logic [WIDTH-1:0] result_d;
  logic            ovf_d;

  always_comb begin
    kind   = decode_cmd(op_add, op_sub);
    negate = (kind == OPK_SUB);
    active = (kind != OPK_IDLE);
  end

  addsub_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .y_raw  (opnd_y),
    .invert (negate),
    .y_eff  (y_sel)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_add (
    .a               (opnd_x),
    .b               (y_sel),
    .cin             (negate),
    .sum             (raw_sum),
    .carry_to_sign   (c_into_sign),
    .carry_from_sign (c_out_sign)
  );

  always_comb begin
    result_d = active ? raw_sum : ZERO_W;
    ovf_d    = active & (c_into_sign ^ c_out_sign);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= ZERO_W;
      ovf    <= 1'b0;
    end else begin
      result <= result_d;
      ovf    <= ovf_d;
    end
  end
endmodule

// File: rtl/signed_addsub_unit_chk.sv
module signed_addsub_unit_chk #(
  parameter int WIDTH = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             op_add,
  input logic             op_sub,
  input logic [WIDTH-1:0] opnd_x,
  input logic [WIDTH-1:0] opnd_y,
  input logic [WIDTH-1:0] result,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] ref_sum;
  logic [WIDTH-1:0] ref_diff;
  assign ref_sum  = opnd_x + opnd_y;
  assign ref_diff = opnd_x - opnd_y;

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_add && !op_sub)) |-> (result == $past(ref_sum))); // R1

  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sub && !op_add)) |-> (result == $past(ref_diff))); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!op_add && !op_sub)) |-> (result == '0 && !ovf)); // R3

  AST_BOTH_SUBTRACT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_add && op_sub)) |-> (result == $past(ref_diff))); // R4

  AST_OVF_ADD_SIGNS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf && $past(op_add && !op_sub)) |->
      ($past(opnd_x[MSB] == opnd_y[MSB]) && (result[MSB] != $past(opnd_x[MSB])))); // R5

  AST_OVF_SUB_SIGNS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf && $past(op_sub)) |->
      ($past(opnd_x[MSB] != opnd_y[MSB]) && (result[MSB] != $past(opnd_x[MSB])))); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && !ovf)); // R7
endmodule

bind signed_addsub_unit signed_addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_add (op_add),
  .op_sub (op_sub),
  .opnd_x (opnd_x),
  .opnd_y (opnd_y),
  .result (result),
  .ovf    (ovf)
);

// File: tb/signed_addsub_unit_test.sv
`timescale 1ns/1ps
module signed_addsub_unit_test;
  localparam int W    = 5;
  localparam int SMAX = (1 << (W-1)) - 1;
  localparam int SMIN = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_add = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] opnd_x = '0;
  logic [W-1:0] opnd_y = '0;
  logic [W-1:0] result;
  logic         ovf;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  signed_addsub_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op_add(op_add), .op_sub(op_sub),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .result(result), .ovf(ovf)
  );

  function automatic int true_val(bit a, bit s, logic [W-1:0] x, logic [W-1:0] y);
    int sx, sy;
    sx = $signed(x);
    sy = $signed(y);
    if (s)      return sx - sy;
    else if (a) return sx + sy;
    else        return 0;
  endfunction

  function automatic logic [W-1:0] exp_res(bit a, bit s, logic [W-1:0] x, logic [W-1:0] y);
    int v;
    v = true_val(a, s, x, y);
    return v[W-1:0];
  endfunction

  function automatic bit exp_ovf(bit a, bit s, logic [W-1:0] x, logic [W-1:0] y);
    int v;
    if (!a && !s) return 1'b0;
    v = true_val(a, s, x, y);
    return (v > SMAX) || (v < SMIN);
  endfunction

  task automatic check(string req, logic [W-1:0] got_r, logic [W-1:0] want_r,
                       bit got_o, bit want_o);
    tests++;
    if (got_r !== want_r) begin
      fails++;
      $display("FAIL %s result got %b expected %b", req, got_r, want_r);
    end
    tests++;
    if (got_o !== want_o) begin
      fails++;
      $display("FAIL %s ovf got %0b expected %0b", req, got_o, want_o);
    end
  endtask

  task automatic apply(bit a, bit s, logic [W-1:0] x, logic [W-1:0] y, string req);
    @(negedge clk);
    op_add = a; op_sub = s; opnd_x = x; opnd_y = y;
    @(posedge clk);
    #1;
    check(req, result, exp_res(a, s, x, y), ovf, exp_ovf(a, s, x, y));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R7: reset state
    opnd_x = 5'd7; opnd_y = 5'd3; op_add = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", result, '0, ovf, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2 directed
    apply(1, 0, 5'd3,  5'd5,  "R1 add 3+5");
    apply(0, 1, 5'd3,  5'd5,  "R2 sub 3-5");
    // R5 overflow corners
    apply(1, 0, 5'd8,  5'd12, "R5 8+12");
    apply(1, 0, 5'(-13), 5'(-7), "R5 -13+-7");
    apply(0, 1, 5'd12, 5'(-8), "R5 12-(-8)");
    apply(1, 0, 5'd15, 5'd0,  "R5 max no ovf");
    apply(0, 1, 5'(-16), 5'd1, "R5 min-1");
    apply(0, 1, 5'd0,  5'(-16), "R5 0-(-16)");
    // R6 discarded carry
    apply(1, 0, 5'(-1), 5'(-1), "R6 -1+-1");
    apply(1, 0, 5'd5,  5'(-5), "R6 5+-5 zero");
    // R3 idle with busy operands
    apply(0, 0, 5'd15, 5'd15, "R3 idle");
    // R4 both raised
    apply(1, 1, 5'd4,  5'd9,  "R4 both");
    apply(1, 1, 5'd12, 5'(-8), "R4 both ovf");

    // R8: output holds its value between edges
    @(negedge clk);
    op_add = 1'b1; op_sub = 1'b0; opnd_x = 5'd1; opnd_y = 5'd2;
    #1;
    check("R8 no change before edge", result, exp_res(1, 1, 5'd12, 5'(-8)),
          ovf, exp_ovf(1, 1, 5'd12, 5'(-8)));
    @(posedge clk);
    #1;
    check("R8 after edge", result, 5'd3, ovf, 1'b0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit a, s;
      logic [W-1:0] x, y;
      int m;
      m = $urandom_range(0, 3);
      a = m[0]; s = m[1];
      x = W'($urandom);
      y = W'($urandom);
      if (!a && !s)      apply(a, s, x, y, "R3 random idle");
      else if (a && s)   apply(a, s, x, y, "R4/R5 random both");
      else if (a)        apply(a, s, x, y, "R1/R5 random add");
      else               apply(a, s, x, y, "R2/R5 random sub");
    end

    // R7 reset in mid-operation
    @(negedge clk);
    rst = 1'b1; op_add = 1'b1; opnd_x = 5'd9; opnd_y = 5'd9;
    @(posedge clk);
    #1;
    check("R7 mid reset", result, '0, ovf, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    apply(1, 0, 5'd9, 5'd9, "R1/R5 after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule